// File: doc/BRIEF.md
# Power-Gating Switch Sequencer

This controller sits in the always-on domain. It switches a gated logic domain off and on through two banks of header switches. The first bank is a weak network with up to eight enables, each with its own request and acknowledge. The weak network charges the virtual rail slowly to limit rush current. The second bank is a strong network with a single request and a single acknowledge. It is closed only after the rail has reached its threshold, which keeps IR drop low in normal running.

Around the switch events the sequencer also orders clock gating, isolation (active low), the domain reset (active low), and the save and restore strobes for the retention flops. The number of weak enables used during power-up can be set to 1, 2, 4 or 8. Fewer enables give less rush current but a longer ramp.

Every acknowledge wait has a programmable timeout. When the timeout expires, an error flag is raised while the sequencer keeps holding its current step.

Power-down runs through these states:
- CLK_STOP: the domain clock is stopped.
- ISO_SET: isolation is asserted.
- SAVE: the save strobe is pulsed.
- RST_SET: the domain reset is asserted.
- STRONG_DN: the strong request is dropped and the sequencer waits for its acknowledge to fall.
- WEAK_DN: the weak requests are dropped and the sequencer waits for all weak acknowledges to fall.
- OFF: the domain is off.

Power-up runs through these states:
- WEAK_UP: the selected weak requests are raised and the sequencer waits for all of their acknowledges.
- STRONG_UP: the strong request is raised and the sequencer waits for its acknowledge.
- RESTORE: the restore strobe is pulsed.
- RST_REL: the domain reset is released.
- ISO_REL: isolation is released.
- ON: the domain clock is enabled.

Top module: `pwr_switch_seq`

## Requirements
- R1: After reset the sequencer is in OFF with these outputs:
  - all weak requests and the strong request low;
  - clk_en, iso_n, rst_dom_n, save and restore all 0;
  - err low;
  - status 2'b00.
- R2: weak_sel selects the weak enables used at power-up. The codes 0, 1, 2 and 3 select 1, 2, 4 and 8 enables, always the lowest-numbered request bits. The selection is captured when a power-up command is accepted, and later changes of weak_sel have no effect on that sequence.
- R3: strong_req rises exactly one cycle after the clock edge on which every selected weak acknowledge is first seen high. It never rises before that.
- R4: Counting the accepting edge as edge 0, with Dw the latest selected weak acknowledge edge and Ds the strong acknowledge delay:
  - restore is high for exactly one cycle, starting after edge Dw+Ds+2, while reset and isolation are still asserted;
  - rst_dom_n rises after edge Dw+Ds+3;
  - iso_n rises after edge Dw+Ds+4;
  - clk_en rises after edge Dw+Ds+5.
- R5: Power-down proceeds in this order, counting the accepting edge as edge 0:
  - clk_en falls after edge 0;
  - iso_n falls after edge 1;
  - a one-cycle save pulse starts after edge 2;
  - rst_dom_n falls after edge 3;
  - strong_req falls after edge 4.
- R6: During power-down, the weak requests drop one cycle after the strong acknowledge is seen low. The sequencer returns to OFF one cycle after all weak acknowledges are seen low.
- R7: cmd_up is ignored unless the state is OFF, and cmd_down is ignored unless the state is ON.
- R8: The timeout works as follows:
  - If a wait lasts timeout_lim cycles, err rises one cycle later.
  - The sequencer holds its current outputs while it waits.
  - It continues normally if the acknowledge arrives late.
  - err stays high until the next accepted command clears it.
- R9: status reads 2'b00 in OFF, 2'b01 in ON and 2'b10 in every other state.
- R10: clk_en is high only while isolation is released, reset is released and strong_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_up | input | 1 | Power-up command pulse |
| cmd_down | input | 1 | Power-down command pulse |
| weak_sel | input | SELW | Weak enable count code (1, 2, 4 or 8 enables) |
| timeout_lim | input | TW | Acknowledge wait limit in cycles |
| weak_req | output | N_WEAK | Weak network switch requests |
| weak_ack | input | N_WEAK | Weak network acknowledges |
| strong_req | output | 1 | Strong network switch request |
| strong_ack | input | 1 | Strong network acknowledge |
| clk_en | output | 1 | Domain clock enable |
| iso_n | output | 1 | Domain isolation, active low |
| rst_dom_n | output | 1 | Domain reset, active low |
| save | output | 1 | Retention save strobe |
| restore | output | 1 | Retention restore strobe |
| err | output | 1 | Sticky acknowledge timeout flag |
| status | output | 2 | 00 off, 01 on, 10 transitioning |

## Verification
Full power-up and power-down cycles are run for all four weak-count codes. The acknowledges are modelled as echoes whose delay grows with the bit index, so the time at which each step occurs shows whether the sequencer waits for the slowest selected acknowledge rather than the first one, and whether it ignores unselected bits. In one run weak_sel is changed mid-sequence, which separates a captured selection from a live one. A stuck acknowledge is then released late, which shows when err is raised, that the step is held, and that err clears on the next command. Commands given in the wrong state confirm that they leave the outputs unchanged.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [3:0] {
        PS_OFF,
        PS_WEAK_UP,
        PS_STRONG_UP,
        PS_RESTORE,
        PS_RST_REL,
        PS_ISO_REL,
        PS_ON,
        PS_CLK_STOP,
        PS_ISO_SET,
        PS_SAVE,
        PS_RST_SET,
        PS_STRONG_DN,
        PS_WEAK_DN
    } pss_state_e;

    localparam logic [1:0] STAT_OFF   = 2'b00;
    localparam logic [1:0] STAT_ON    = 2'b01;
    localparam logic [1:0] STAT_TRANS = 2'b10;

endpackage

// File: rtl/pss_weak_mask.sv
module pss_weak_mask #(
    parameter int N_WEAK = 8,
    parameter int SELW   = 2
) (
    input  logic [SELW-1:0]   sel,
    output logic [N_WEAK-1:0] mask
);
    logic [31:0] lanes;

    always_comb begin
        lanes = 32'(1) << sel;
        if (lanes > 32'(N_WEAK)) begin
            lanes = 32'(N_WEAK);
        end
    end

    for (genvar g = 0; g < N_WEAK; g++) begin : g_lane
        assign mask[g] = (32'(g) < lanes);
    end
endmodule

// File: rtl/pss_ack_timer.sv
module pss_ack_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (cnt != limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = active && (cnt == limit);
endmodule

// File: rtl/pwr_switch_seq.sv
module pwr_switch_seq
    import pss_pkg::*;
#(
    parameter int N_WEAK = 8,
    parameter int TW     = 16,
    localparam int SELW  = $clog2($clog2(N_WEAK) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_up,
    input  logic              cmd_down,
    input  logic [SELW-1:0]   weak_sel,
    input  logic [TW-1:0]     timeout_lim,
    output logic [N_WEAK-1:0] weak_req,
    input  logic [N_WEAK-1:0] weak_ack,
    output logic              strong_req,
    input  logic              strong_ack,
    output logic              clk_en,
    output logic              iso_n,
    output logic              rst_dom_n,
    output logic              save,
    output logic              restore,
    output logic              err,
    output logic [1:0]        status
);
    pss_state_e        state, state_nx;
    logic [N_WEAK-1:0] sel_mask, mask_q;
    logic              up_go, down_go, weak_all_up, weak_all_dn;
    logic              waiting, tmo_hit, err_q;

    pss_weak_mask #(.N_WEAK(N_WEAK), .SELW(SELW)) u_mask (
        .sel  (weak_sel),
        .mask (sel_mask)
    );

    assign up_go       = (state == PS_OFF) && cmd_up;
    assign down_go     = (state == PS_ON) && cmd_down;
    assign weak_all_up = ((weak_ack & mask_q) == mask_q);
    assign weak_all_dn = (weak_ack == '0);

    assign waiting = ((state == PS_WEAK_UP)   && !weak_all_up) ||
                     ((state == PS_STRONG_UP) && !strong_ack)  ||
                     ((state == PS_STRONG_DN) &&  strong_ack)  ||
                     ((state == PS_WEAK_DN)   && !weak_all_dn);

    pss_ack_timer #(.TW(TW)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (waiting),
        .limit   (timeout_lim),
        .expired (tmo_hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PS_OFF;
        end else begin
            state <= state_nx;
        end
    end

    // Captured weak selection and sticky timeout flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (up_go) begin
                mask_q <= sel_mask;
            end
            if (up_go || down_go) begin
                err_q <= 1'b0;
            end else if (tmo_hit) begin
                err_q <= 1'b1;
            end
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            PS_OFF:       if (cmd_up) state_nx = PS_WEAK_UP;
            PS_WEAK_UP:   if (weak_all_up) state_nx = PS_STRONG_UP;
            PS_STRONG_UP: if (strong_ack) state_nx = PS_RESTORE;
            PS_RESTORE:   state_nx = PS_RST_REL;
            PS_RST_REL:   state_nx = PS_ISO_REL;
            PS_ISO_REL:   state_nx = PS_ON;
            PS_ON:        if (cmd_down) state_nx = PS_CLK_STOP;
            PS_CLK_STOP:  state_nx = PS_ISO_SET;
            PS_ISO_SET:   state_nx = PS_SAVE;
            PS_SAVE:      state_nx = PS_RST_SET;
            PS_RST_SET:   state_nx = PS_STRONG_DN;
            PS_STRONG_DN: if (!strong_ack) state_nx = PS_WEAK_DN;
            PS_WEAK_DN:   if (weak_all_dn) state_nx = PS_OFF;
            default:      state_nx = PS_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        weak_req   = '0;
        strong_req = 1'b0;
        clk_en     = 1'b0;
        iso_n      = 1'b0;
        rst_dom_n  = 1'b0;
        save       = 1'b0;
        restore    = 1'b0;
        status     = STAT_TRANS;
        unique case (state)
            PS_OFF: status = STAT_OFF;
            PS_WEAK_UP: weak_req = mask_q;
            PS_STRONG_UP: begin
                weak_req   = mask_q;
                strong_req = 1'b1;
            end
            PS_RESTORE: begin
                weak_req   = mask_q;
                strong_req = 1'b1;
                restore    = 1'b1;
            end
            PS_RST_REL: begin
                weak_req   = mask_q;
                strong_req = 1'b1;
                rst_dom_n  = 1'b1;
            end
            PS_ISO_REL, PS_CLK_STOP: begin
                weak_req   = mask_q;
                strong_req = 1'b1;
                rst_dom_n  = 1'b1;
                iso_n      = 1'b1;
            end
            PS_ON: begin
                weak_req   = mask_q;
                strong_req = 1'b1;
                rst_dom_n  = 1'b1;
                iso_n      = 1'b1;
                clk_en     = 1'b1;
                status     = STAT_ON;
            end
            PS_ISO_SET: begin
                weak_req   = mask_q;
                strong_req = 1'b1;
                rst_dom_n  = 1'b1;
            end
            PS_SAVE: begin
                weak_req   = mask_q;
                strong_req = 1'b1;
                rst_dom_n  = 1'b1;
                save       = 1'b1;
            end
            PS_RST_SET: begin
                weak_req   = mask_q;
                strong_req = 1'b1;
            end
            PS_STRONG_DN: weak_req = mask_q;
            PS_WEAK_DN: ;
            default: status = STAT_OFF;
        endcase
    end

    assign err = err_q;
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
    parameter int N_WEAK = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_WEAK-1:0] weak_req,
    input logic [N_WEAK-1:0] weak_ack,
    input logic              strong_req,
    input logic              clk_en,
    input logic              iso_n,
    input logic              rst_dom_n,
    input logic              save,
    input logic              restore,
    input logic              err,
    input logic [1:0]        status
);
    a_r3_strong_after_weak: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strong_req) |-> ($past(weak_req) != '0) &&
                              (($past(weak_ack) & $past(weak_req)) == $past(weak_req)));

    a_r5_strong_off_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strong_req) |-> !iso_n && !rst_dom_n && !clk_en);

    a_r10_clk_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> iso_n && rst_dom_n && strong_req);

    a_r4_strobes_safe: assert property (@(posedge clk) disable iff (!rst_n)
        (save || restore) |-> !(save && restore) && !clk_en && !iso_n);

    a_r9_on_means_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b01) |-> clk_en);

    a_r2_low_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        ((({1'b0, weak_req} + 1'b1) & {1'b0, weak_req}) == '0));

    a_r8_err_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($past(status) == 2'b10));
endmodule

bind pwr_switch_seq pss_checker #(.N_WEAK(N_WEAK)) u_pss_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .weak_req   (weak_req),
    .weak_ack   (weak_ack),
    .strong_req (strong_req),
    .clk_en     (clk_en),
    .iso_n      (iso_n),
    .rst_dom_n  (rst_dom_n),
    .save       (save),
    .restore    (restore),
    .err        (err),
    .status     (status)
);

// File: tb/tb_pwr_switch_seq.sv
`timescale 1ns/1ps
module tb_pwr_switch_seq;
    localparam int NW = 8;
    localparam int WB = 2;   // weak bit i acknowledge delay = WB + i cycles
    localparam int DS = 3;   // strong acknowledge delay

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_up = 1'b0, cmd_down = 1'b0;
    logic [1:0] weak_sel = 2'd0;
    logic [15:0] timeout_lim = 16'd40;
    logic [NW-1:0] weak_req, weak_ack, kill;
    logic strong_req, strong_ack;
    logic clk_en, iso_n, rst_dom_n, save, restore, err;
    logic [1:0] status;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    pwr_switch_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_up(cmd_up), .cmd_down(cmd_down),
        .weak_sel(weak_sel), .timeout_lim(timeout_lim),
        .weak_req(weak_req), .weak_ack(weak_ack),
        .strong_req(strong_req), .strong_ack(strong_ack),
        .clk_en(clk_en), .iso_n(iso_n), .rst_dom_n(rst_dom_n),
        .save(save), .restore(restore), .err(err), .status(status)
    );

    // Acknowledge model: delayed echoes of the requests
    logic [15:0] wsh [NW];
    logic [3:0]  ssh;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) wsh[i] <= '0;
            ssh <= '0;
        end else begin
            for (int i = 0; i < NW; i++) wsh[i] <= {wsh[i][14:0], weak_req[i]};
            ssh <= {ssh[2:0], strong_req};
        end
    end
    always_comb begin
        for (int i = 0; i < NW; i++) weak_ack[i] = wsh[i][WB+i-1] & ~kill[i];
        strong_ack = ssh[DS-1];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_cmd(input bit up);
        @(negedge clk);
        cmd_up = up;
        cmd_down = !up;
        @(negedge clk);
        cmd_up = 1'b0;
        cmd_down = 1'b0;
    endtask

    task automatic run_up(input int s, input bit change_sel);
        int n, dw, t_str, t_res, t_rst, t_iso, t_clk, rcnt, badmask;
        logic [NW-1:0] exp_mask;
        dw = WB + (1 << s) - 1;
        exp_mask = NW'((1 << (1 << s)) - 1);
        weak_sel = 2'(s);
        do_cmd(1'b1);
        chk(weak_req == exp_mask, "R2 weak request mask", int'(weak_req), int'(exp_mask));
        if (change_sel) weak_sel = 2'(3 - s);
        t_str = -1; t_res = -1; t_rst = -1; t_iso = -1; t_clk = -1;
        rcnt = 0; badmask = 0; n = 0;
        while (n < 500) begin
            if (strong_req && t_str < 0) t_str = n;
            if (restore) begin
                rcnt++;
                if (t_res < 0) t_res = n;
                if (rst_dom_n || iso_n) badmask++;
            end
            if (rst_dom_n && t_rst < 0) t_rst = n;
            if (iso_n && t_iso < 0) t_iso = n;
            if (clk_en && t_clk < 0) t_clk = n;
            if (weak_req != exp_mask) badmask++;
            if (status == 2'b01) break;
            @(negedge clk);
            n++;
        end
        chk(badmask == 0, "R2 mask held / R4 restore under reset", badmask, 0);
        chk(t_str == dw + 1, "R3 strong request timing", t_str, dw + 1);
        chk(t_res == dw + DS + 2, "R4 restore timing", t_res, dw + DS + 2);
        chk(rcnt == 1, "R4 restore width", rcnt, 1);
        chk(t_rst == dw + DS + 3, "R4 reset release", t_rst, dw + DS + 3);
        chk(t_iso == dw + DS + 4, "R4 isolation release", t_iso, dw + DS + 4);
        chk(t_clk == dw + DS + 5, "R4 clock enable", t_clk, dw + DS + 5);
        chk(n == dw + DS + 5, "R9 status ON timing", n, dw + DS + 5);
    endtask

    task automatic run_down(input int s);
        int n, dw, t_c, t_i, t_s, t_r, t_st, t_w, scnt;
        dw = WB + (1 << s) - 1;
        do_cmd(1'b0);
        t_c = -1; t_i = -1; t_s = -1; t_r = -1; t_st = -1; t_w = -1;
        scnt = 0; n = 0;
        while (n < 500) begin
            if (!clk_en && t_c < 0) t_c = n;
            if (!iso_n && t_i < 0) t_i = n;
            if (save) begin
                scnt++;
                if (t_s < 0) t_s = n;
            end
            if (!rst_dom_n && t_r < 0) t_r = n;
            if (!strong_req && t_st < 0) t_st = n;
            if (weak_req == '0 && t_w < 0) t_w = n;
            if (status == 2'b00) break;
            @(negedge clk);
            n++;
        end
        chk(t_c == 0, "R5 clock stop", t_c, 0);
        chk(t_i == 1, "R5 isolation", t_i, 1);
        chk(t_s == 2 && scnt == 1, "R5 save pulse", t_s, 2);
        chk(t_r == 3, "R5 domain reset", t_r, 3);
        chk(t_st == 4, "R5 strong request drop", t_st, 4);
        chk(t_w == DS + 5, "R6 weak request drop", t_w, DS + 5);
        chk(n == dw + DS + 6, "R6 OFF timing", n, dw + DS + 6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        kill = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(weak_req == '0 && !strong_req, "R1 requests low", int'(weak_req), 0);
        chk(!clk_en && !iso_n && !rst_dom_n && !save && !restore,
            "R1 domain controls", int'({clk_en, iso_n, rst_dom_n, save, restore}), 0);
        chk(!err && status == 2'b00, "R1 err/status", int'({err, status}), 0);

        // R7 cmd_down ignored while OFF
        do_cmd(1'b0);
        repeat (3) @(negedge clk);
        chk(status == 2'b00 && weak_req == '0, "R7 down ignored in OFF", int'(status), 0);

        // R2/R3/R4/R5/R6 sweep over all weak counts
        for (int s = 0; s < 4; s++) begin
            run_up(s, s == 1);
            if (s == 2) begin
                do_cmd(1'b1);
                repeat (3) @(negedge clk);
                chk(status == 2'b01 && clk_en, "R7 up ignored in ON", int'(status), 1);
            end
            run_down(s);
        end

        // R8 timeout on a stuck weak acknowledge
        timeout_lim = 16'd20;
        kill = 8'b0000_0010;
        weak_sel = 2'd3;
        do_cmd(1'b1);
        repeat (20) @(negedge clk);
        chk(!err, "R8 err not before limit", int'(err), 0);
        @(negedge clk);
        chk(err, "R8 err at limit", int'(err), 1);
        repeat (10) @(negedge clk);
        chk(status == 2'b10 && !strong_req && weak_req == 8'hFF,
            "R8 step held", int'(strong_req), 0);
        kill = '0;
        n = 0;
        while (status != 2'b01 && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(status == 2'b01 && err, "R8 late ack completes, err sticky", int'({status, err}), 3);
        do_cmd(1'b0);
        chk(!err, "R8 err cleared by command", int'(err), 0);
        n = 0;
        while (status != 2'b00 && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(status == 2'b00, "R9 back to OFF", int'(status), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule